// File: doc/BRIEF.md
# Floating-point exception status unit

This block keeps the exception state of a floating-point unit: per-exception cause bits, enable bits and sticky flags, plus the flush-to-zero control and the rounding mode, all packed into one 32-bit status word. When an arithmetic operation completes, the datapath presents the raw operand and result bit patterns together with its own raw exception indications. The block classifies the operands and the result, works out which causes the operation raised, updates the sticky flags, substitutes a fixed value for NaN or subnormal results, and decides whether the core must take a floating-point trap.

Software rewrites the status word through a write port. The new contents take effect on the next cycle, and the trap condition is evaluated again from the written word. All outputs are registered, with one cycle of latency from the inputs. A trap is signalled as a pulse in the same cycle as the status update that caused it, and the destination register write enable is held low in that cycle.

Top module: `fpx_status_unit`

## Requirements
- R1: Status word layout: rounding mode in bits [1:0], sticky flags in [6:2], enables in [11:7], causes in [17:12], flush-to-zero in bit 24. Exception index inside each field: 0 inexact, 1 underflow, 2 overflow, 3 divide-by-zero, 4 invalid; cause index 5 (word bit 17) is unimplemented-operation. Other bits read as zero. After reset the word, trap and write enable are all zero.
- R2: A trap is raised when any cause bit is set whose enable is set; the unimplemented cause traps whatever the enables hold.
- R3: For each of the five maskable exceptions, the sticky flag is set by an operation only when its cause is set and its enable is clear; flags are never cleared by operations, only by a status write.
- R4: A quiet NaN operand (exponent all ones, top mantissa bit set) sets the invalid cause; a signalling NaN or subnormal operand sets unimplemented. Operand B is examined only when opb_used is high. If the operand causes trap, the raw indications and the result add nothing.
- R5: A NaN result is replaced by 0x7FBFFFFF in single format (upper 32 bits zero) or 0x7FF7FFFFFFFFFFFF in double format; a normal, zero or infinite result passes unchanged.
- R6: A subnormal result sets unimplemented when flush-to-zero is clear or the underflow or inexact enable is set; otherwise it sets both underflow and inexact causes and is flushed.
- R7: Flushed value by rounding mode: modes 0 and 1 give a zero of the result's sign; mode 2 gives -0 for negative and +minimum normal for positive; mode 3 gives -minimum normal for negative and +0 for positive.
- R8: A raw underflow indication under the same condition as in R6 sets only unimplemented (besides operand causes); no other raw indication is recorded for that operation.
- R9: Otherwise each raw indication bit i sets cause bit i.
- R10: A status write stores the word (undefined bits zero) and raises a trap when the written causes meet the written enables; an operation presented in the same cycle is dropped.
- R11: Each operation replaces the whole cause field; causes hold between operations. The trap output is high for exactly the cycle after a trapping operation or write.
- R12: The result write enable rises the cycle after an operation that does not trap, and is low after a trapping operation, an idle cycle or a status write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | An operation outcome is presented this cycle |
| op_dbl | input | 1 | 1 = double format, 0 = single format (low 32 bits) |
| opb_used | input | 1 | Operand B takes part in the operation |
| opa_val | input | 64 | Operand A bit pattern |
| opb_val | input | 64 | Operand B bit pattern |
| res_val | input | 64 | Raw result bit pattern from the datapath |
| raw_exc | input | 5 | Raw exception indications, indexed as in R1 |
| csr_we | input | 1 | Status word write strobe |
| csr_wdata | input | 32 | Status word write data |
| csr_q | output | 32 | Current status word |
| trap | output | 1 | Floating-point trap request pulse |
| res_we | output | 1 | Destination register write enable |
| res_out | output | 64 | Result after NaN or subnormal substitution |

## Verification
The assertions assume the enables in the status word change only through the write port, so that a newly set flag can be checked against the enables read in the same cycle, and that every trap is backed by a cause-enable pair visible in the stored word. The stimulus holds op_valid and csr_we to one cycle per event, drives the upper operand half freely in single format to show it is ignored, and places a status write on the same cycle as an operation only in the one case that tests the drop rule.

// File: rtl/fpx_pkg.sv
package fpx_pkg;
  localparam int VAL_W   = 64;
  localparam int SGL_W   = 32;
  localparam int CSR_W   = 32;
  localparam int EXC_W   = 5;
  localparam int CAUSE_W = EXC_W + 1;
  localparam int RM_W    = 2;

  localparam int EX_INEXACT = 0;
  localparam int EX_UNDER   = 1;
  localparam int EX_OVER    = 2;
  localparam int EX_DIVZ    = 3;
  localparam int EX_INVAL   = 4;
  localparam int EX_UNIMP   = 5;

  localparam int RM_LSB    = 0;
  localparam int FLAG_LSB  = RM_LSB + RM_W;
  localparam int EN_LSB    = FLAG_LSB + EXC_W;
  localparam int CAUSE_LSB = EN_LSB + EXC_W;
  localparam int FTZ_BIT   = 24;

  localparam logic [CSR_W-1:0] CSR_MASK =
    (CSR_W'(1) << FTZ_BIT) | ((CSR_W'(1) << (CAUSE_LSB + CAUSE_W)) - CSR_W'(1));

  localparam logic [SGL_W-1:0] SGL_NAN_SUB = 32'h7FBF_FFFF;
  localparam logic [VAL_W-1:0] DBL_NAN_SUB = 64'h7FF7_FFFF_FFFF_FFFF;
  localparam logic [SGL_W-1:0] SGL_MIN_NRM = 32'h0080_0000;
  localparam logic [VAL_W-1:0] DBL_MIN_NRM = 64'h0010_0000_0000_0000;

  typedef struct packed {
    logic is_nan;
    logic is_qnan;
    logic is_sub;
  } fcls_t;
endpackage

// File: rtl/fpx_classify.sv
module fpx_classify
  import fpx_pkg::*;
(
  input  logic [VAL_W-1:0] val,
  input  logic             dbl,
  output fcls_t            cls
);
  logic exp_ones, exp_zero, man_nz, man_top;

  always_comb begin
    if (dbl) begin
      exp_ones = &val[62:52];
      exp_zero = ~|val[62:52];
      man_nz   = |val[51:0];
      man_top  = val[51];
    end else begin
      exp_ones = &val[30:23];
      exp_zero = ~|val[30:23];
      man_nz   = |val[22:0];
      man_top  = val[22];
    end
    cls.is_nan  = exp_ones & man_nz;
    cls.is_qnan = exp_ones & man_top;
    cls.is_sub  = exp_zero & man_nz;
  end
endmodule

// File: rtl/fpx_cause.sv
module fpx_cause
  import fpx_pkg::*;
(
  input  fcls_t              opa_cls,
  input  fcls_t              opb_cls,
  input  logic               opb_used,
  input  logic               res_sub,
  input  logic [EXC_W-1:0]   raw_exc,
  input  logic [EXC_W-1:0]   enables,
  input  logic               ftz,
  output logic [CAUSE_W-1:0] cause
);
  logic [CAUSE_W-1:0] en_full;
  logic [CAUSE_W-1:0] c_opnd, c_raw, c_res;
  logic               escalate, stop_opnd, stop_raw;
  fcls_t              ops [2];

  assign ops[0] = opa_cls;
  assign ops[1] = opb_used ? opb_cls : '0;

  always_comb begin
    en_full  = {1'b1, enables};
    escalate = ~ftz | enables[EX_UNDER] | enables[EX_INEXACT];

    c_opnd = '0;
    for (int k = 0; k < 2; k++) begin
      if (ops[k].is_nan && ops[k].is_qnan)  c_opnd[EX_INVAL] = 1'b1;
      if (ops[k].is_nan && !ops[k].is_qnan) c_opnd[EX_UNIMP] = 1'b1;
      if (ops[k].is_sub)                    c_opnd[EX_UNIMP] = 1'b1;
    end
    stop_opnd = |(c_opnd & en_full);

    c_raw = c_opnd;
    if (raw_exc[EX_UNDER] && escalate) c_raw[EX_UNIMP] = 1'b1;
    else                               c_raw = c_opnd | {1'b0, raw_exc};
    stop_raw = |(c_raw & en_full);

    c_res = c_raw;
    if (res_sub) begin
      if (escalate) c_res[EX_UNIMP] = 1'b1;
      else begin
        c_res[EX_UNDER]   = 1'b1;
        c_res[EX_INEXACT] = 1'b1;
      end
    end

    if (stop_opnd)     cause = c_opnd;
    else if (stop_raw) cause = c_raw;
    else               cause = c_res;
  end
endmodule

// File: rtl/fpx_subst.sv
module fpx_subst
  import fpx_pkg::*;
(
  input  logic [VAL_W-1:0] val,
  input  logic             dbl,
  input  logic             is_nan,
  input  logic             is_sub,
  input  logic [RM_W-1:0]  rm,
  output logic [VAL_W-1:0] val_out
);
  logic             neg;
  logic [VAL_W-1:0] sign_v, min_v, nan_v, flush_v;

  always_comb begin
    neg    = dbl ? val[VAL_W-1] : val[SGL_W-1];
    sign_v = dbl ? {1'b1, {(VAL_W-1){1'b0}}} : {{SGL_W{1'b0}}, 1'b1, {(SGL_W-1){1'b0}}};
    min_v  = dbl ? DBL_MIN_NRM : {{SGL_W{1'b0}}, SGL_MIN_NRM};
    nan_v  = dbl ? DBL_NAN_SUB : {{SGL_W{1'b0}}, SGL_NAN_SUB};

    unique case (rm)
      2'd2:    flush_v = neg ? sign_v : min_v;
      2'd3:    flush_v = neg ? (sign_v | min_v) : '0;
      default: flush_v = neg ? sign_v : '0;
    endcase

    if (is_nan)      val_out = nan_v;
    else if (is_sub) val_out = flush_v;
    else             val_out = val;
  end
endmodule

// File: rtl/fpx_status_unit.sv
module fpx_status_unit
  import fpx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic              op_dbl,
  input  logic              opb_used,
  input  logic [VAL_W-1:0]  opa_val,
  input  logic [VAL_W-1:0]  opb_val,
  input  logic [VAL_W-1:0]  res_val,
  input  logic [EXC_W-1:0]  raw_exc,
  input  logic              csr_we,
  input  logic [CSR_W-1:0]  csr_wdata,
  output logic [CSR_W-1:0]  csr_q,
  output logic              trap,
  output logic              res_we,
  output logic [VAL_W-1:0]  res_out
);
  fcls_t              cls_v [3];
  logic [VAL_W-1:0]   cls_in [3];
  logic [CAUSE_W-1:0] op_cause;
  logic [VAL_W-1:0]   sub_val;

  logic [CSR_W-1:0]   csr_d, wr_word;
  logic               trap_d, res_we_d, csr_en, res_en;
  logic [EXC_W-1:0]   cur_en, cur_flag;

  assign cls_in[0] = opa_val;
  assign cls_in[1] = opb_val;
  assign cls_in[2] = res_val;

  for (genvar g = 0; g < 3; g++) begin : g_cls
    fpx_classify u_cls (
      .val (cls_in[g]),
      .dbl (op_dbl),
      .cls (cls_v[g])
    );
  end

  assign cur_en   = csr_q[EN_LSB +: EXC_W];
  assign cur_flag = csr_q[FLAG_LSB +: EXC_W];

  fpx_cause u_cause (
    .opa_cls  (cls_v[0]),
    .opb_cls  (cls_v[1]),
    .opb_used (opb_used),
    .res_sub  (cls_v[2].is_sub),
    .raw_exc  (raw_exc),
    .enables  (cur_en),
    .ftz      (csr_q[FTZ_BIT]),
    .cause    (op_cause)
  );

  fpx_subst u_subst (
    .val     (res_val),
    .dbl     (op_dbl),
    .is_nan  (cls_v[2].is_nan),
    .is_sub  (cls_v[2].is_sub),
    .rm      (csr_q[RM_LSB +: RM_W]),
    .val_out (sub_val)
  );

  always_comb begin
    wr_word  = csr_wdata & CSR_MASK;
    csr_d    = csr_q;
    trap_d   = 1'b0;
    res_we_d = 1'b0;
    csr_en   = 1'b0;
    res_en   = 1'b0;
    if (csr_we) begin
      csr_en = 1'b1;
      csr_d  = wr_word;
      trap_d = |(wr_word[CAUSE_LSB +: CAUSE_W] & {1'b1, wr_word[EN_LSB +: EXC_W]});
    end else if (op_valid) begin
      csr_en = 1'b1;
      res_en = 1'b1;
      csr_d[CAUSE_LSB +: CAUSE_W] = op_cause;
      csr_d[FLAG_LSB +: EXC_W]    = cur_flag | (op_cause[EXC_W-1:0] & ~cur_en);
      trap_d   = |(op_cause & {1'b1, cur_en});
      res_we_d = ~trap_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      csr_q  <= '0;
      trap   <= 1'b0;
      res_we <= 1'b0;
    end else begin
      if (csr_en) csr_q <= csr_d;
      trap   <= trap_d;
      res_we <= res_we_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      res_out <= '0;
    else if (res_en) res_out <= sub_val;
  end
endmodule

// File: rtl/fpx_status_chk.sv
module fpx_status_chk
  import fpx_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             op_valid,
  input logic             csr_we,
  input logic [CSR_W-1:0] csr_q,
  input logic             trap,
  input logic             res_we
);
  // R2: every trap is backed by a stored cause that is enabled (or unimplemented)
  a_r2_trap_backed: assert property (@(posedge clk) disable iff (!rst_n)
    trap |-> |(csr_q[CAUSE_LSB +: CAUSE_W] & {1'b1, csr_q[EN_LSB +: EXC_W]}));

  // R3: flags only grow unless software writes the word
  a_r3_flags_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !csr_we |=> ((csr_q[FLAG_LSB +: EXC_W] & $past(csr_q[FLAG_LSB +: EXC_W]))
                 == $past(csr_q[FLAG_LSB +: EXC_W])));

  // R3: an operation never sets a flag whose enable is set
  a_r3_flag_disabled_only: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !csr_we) |=> ((csr_q[FLAG_LSB +: EXC_W] & ~$past(csr_q[FLAG_LSB +: EXC_W])
                                & csr_q[EN_LSB +: EXC_W]) == '0));

  // R11: no event, no trap
  a_r11_trap_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (!op_valid && !csr_we) |=> !trap);

  // R12: a trapped operation writes no result
  a_r12_no_write_on_trap: assert property (@(posedge clk) disable iff (!rst_n)
    trap |-> !res_we);

  // R10: a status write drops a coincident operation
  a_r10_write_drops_op: assert property (@(posedge clk) disable iff (!rst_n)
    csr_we |=> !res_we);

  // R12: the write enable follows an operation
  a_r12_we_from_op: assert property (@(posedge clk) disable iff (!rst_n)
    res_we |-> $past(op_valid));
endmodule

bind fpx_status_unit fpx_status_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .op_valid (op_valid),
  .csr_we   (csr_we),
  .csr_q    (csr_q),
  .trap     (trap),
  .res_we   (res_we)
);

// File: tb/test_fpx_status_unit.sv
`timescale 1ns/1ps
module test_fpx_status_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0, op_dbl = 1'b0, opb_used = 1'b0;
  logic [63:0] opa_val = '0, opb_val = '0, res_val = '0;
  logic [4:0]  raw_exc = '0;
  logic        csr_we = 1'b0;
  logic [31:0] csr_wdata = '0;
  logic [31:0] csr_q;
  logic        trap, res_we;
  logic [63:0] res_out;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  fpx_status_unit i_fpx_status_unit (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_dbl(op_dbl),
    .opb_used(opb_used), .opa_val(opa_val), .opb_val(opb_val),
    .res_val(res_val), .raw_exc(raw_exc), .csr_we(csr_we),
    .csr_wdata(csr_wdata), .csr_q(csr_q), .trap(trap), .res_we(res_we),
    .res_out(res_out)
  );

  typedef struct {
    string       tag;
    logic [31:0] csr;
    logic        trp;
    logic        we;
    logic [63:0] res;
  } exp_t;
  exp_t sb_q [$];

  logic [31:0] m_csr = '0;

  // bench view of a value: 0 plain, 1 quiet NaN, 2 signalling NaN, 3 subnormal
  function automatic int kind(logic [63:0] v, logic d);
    logic [10:0] e; logic [51:0] m; logic q;
    if (d) begin e = v[62:52]; m = v[51:0]; q = v[51]; end
    else begin e = {3'b0, v[30:23]}; m = {29'b0, v[22:0]}; q = v[22]; end
    if ((d && e == 11'h7FF) || (!d && e == 11'h0FF)) begin
      if (m == 0) return 0;
      return q ? 1 : 2;
    end
    if (e == 0 && m != 0) return 3;
    return 0;
  endfunction

  task automatic step(input string tag, input logic ov, input logic d, input logic bu,
                      input logic [63:0] a, input logic [63:0] b, input logic [63:0] r,
                      input logic [4:0] raw, input logic we, input logic [31:0] wd);
    exp_t e;
    logic [4:0] en, fl;
    logic [5:0] c;
    logic esc, neg;
    int ka, kb, kr;
    @(negedge clk);
    op_valid = ov; op_dbl = d; opb_used = bu; opa_val = a; opb_val = b;
    res_val = r; raw_exc = raw; csr_we = we; csr_wdata = wd;
    e.tag = tag; e.trp = 1'b0; e.we = 1'b0; e.res = '0;
    en = m_csr[11:7]; fl = m_csr[6:2];
    if (we) begin
      m_csr = wd & 32'h0103_FFFF;
      e.trp = (m_csr[17] != 0) || ((m_csr[16:12] & m_csr[11:7]) != 0);
    end else if (ov) begin
      esc = !m_csr[24] || en[1] || en[0];
      ka = kind(a, d); kb = bu ? kind(b, d) : 0; kr = kind(r, d);
      c = '0;
      if (ka == 1 || kb == 1) c[4] = 1;
      if (ka >= 2 || kb >= 2) c[5] = 1;
      if (!(c[5] || (c[4] && en[4]))) begin
        if (raw[1] && esc) c[5] = 1;
        else c[4:0] = c[4:0] | raw;
        if (!(c[5] || ((c[4:0] & en) != 0))) begin
          if (kr == 3) begin
            if (esc) c[5] = 1; else begin c[1] = 1; c[0] = 1; end
          end
        end
      end
      m_csr[17:12] = c;
      m_csr[6:2] = fl | (c[4:0] & ~en);
      e.trp = c[5] || ((c[4:0] & en) != 0);
      e.we = !e.trp;
      neg = d ? r[63] : r[31];
      if (kr == 1 || kr == 2) e.res = d ? 64'h7FF7_FFFF_FFFF_FFFF : 64'h0000_0000_7FBF_FFFF;
      else if (kr == 3) begin
        case (m_csr[1:0])
          2'd2:    e.res = neg ? (d ? 64'h8000_0000_0000_0000 : 64'h8000_0000)
                               : (d ? 64'h0010_0000_0000_0000 : 64'h0080_0000);
          2'd3:    e.res = neg ? (d ? 64'h8010_0000_0000_0000 : 64'h8080_0000) : 64'h0;
          default: e.res = neg ? (d ? 64'h8000_0000_0000_0000 : 64'h8000_0000) : 64'h0;
        endcase
      end else e.res = r;
    end
    e.csr = m_csr;
    sb_q.push_back(e);
  endtask

  task automatic idle(input string tag);
    step(tag, 0, 0, 0, '0, '0, '0, '0, 0, '0);
  endtask

  task automatic wr(input string tag, input logic [31:0] wd);
    step(tag, 0, 0, 0, '0, '0, '0, '0, 1, wd);
  endtask

  task automatic op(input string tag, input logic d, input logic bu, input logic [63:0] a,
                    input logic [63:0] b, input logic [63:0] r, input logic [4:0] raw);
    step(tag, 1, d, bu, a, b, r, raw, 0, '0);
  endtask

  // monitor: compare each cycle's registered outputs against the scoreboard
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        n_chk++;
        if (csr_q !== e.csr || trap !== e.trp || res_we !== e.we ||
            (e.we && res_out !== e.res)) begin
          n_bad++;
          $display("FAIL %s: csr=%h trap=%b we=%b res=%h expected csr=%h trap=%b we=%b res=%h",
                   e.tag, csr_q, trap, res_we, res_out, e.csr, e.trp, e.we, e.res);
        end
      end
    end
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  localparam logic [63:0] S_ONE  = 64'h3F80_0000;
  localparam logic [63:0] S_QNAN = 64'h7FC0_0000;
  localparam logic [63:0] S_SNAN = 64'h7F80_0001;
  localparam logic [63:0] S_SUBP = 64'h0000_0001;
  localparam logic [63:0] S_SUBN = 64'h8000_0001;
  localparam logic [63:0] D_ONE  = 64'h3FF0_0000_0000_0000;
  localparam logic [63:0] D_QNAN = 64'h7FF8_0000_0000_0000;
  localparam logic [63:0] D_SUBP = 64'h0000_0000_0000_0001;
  localparam logic [63:0] D_SUBN = 64'h8000_0000_0000_0001;

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    n_chk++;
    if (csr_q !== 32'h0 || trap !== 1'b0 || res_we !== 1'b0) begin
      n_bad++;
      $display("FAIL R1 reset: csr=%h trap=%b we=%b expected 0/0/0", csr_q, trap, res_we);
    end
    @(negedge clk); rst_n = 1'b1;

    // R12 plain operation; upper half of single operands ignored
    op("R12 plain single", 0, 1, 64'hDEAD_0000_0000_0000 | S_ONE, S_ONE, 64'h1234_5678_4000_0000, 5'b0);
    op("R9 raw inexact, flag set (R3)", 1, 1, D_ONE, D_ONE, D_ONE, 5'b00001);
    op("R11 clean op clears cause, R3 flag stays", 1, 1, D_ONE, D_ONE, D_ONE, 5'b0);
    // R10 enable overflow through a write, R1 undefined bits dropped
    wr("R10 write enables overflow", 32'hFE00_0000 | (32'h1 << 9));
    op("R2 enabled overflow traps, no flag", 0, 1, S_ONE, S_ONE, S_ONE, 5'b00100);
    idle("R11 trap is a pulse, cause held");
    op("R9 raw divzero disabled", 0, 1, S_ONE, S_ONE, S_ONE, 5'b01000);
    wr("R10 clear word", 32'h0);
    op("R4 quiet NaN operand -> invalid", 0, 1, S_ONE, S_QNAN, S_QNAN, 5'b0);
    op("R4 signalling NaN operand traps (R2)", 0, 1, S_SNAN, S_ONE, S_ONE, 5'b00100);
    op("R4 subnormal B unused is ignored", 0, 0, S_ONE, S_SUBP, S_ONE, 5'b0);
    op("R4 subnormal A operand", 1, 1, D_SUBP, D_ONE, D_ONE, 5'b0);
    wr("R10 enable invalid", 32'h1 << 11);
    op("R4 enabled invalid operand stops raw and result", 1, 1, D_QNAN, D_ONE, D_SUBP, 5'b00111);
    wr("R10 clear word again", 32'h0);
    op("R5 single NaN result", 0, 1, S_ONE, S_ONE, S_SNAN, 5'b0);
    op("R5 double NaN result", 1, 1, D_ONE, D_ONE, D_QNAN, 5'b10000);
    op("R6 subnormal result, no flush -> unimplemented", 0, 1, S_ONE, S_ONE, S_SUBP, 5'b0);
    op("R8 raw underflow escalated, inexact dropped", 0, 1, S_ONE, S_ONE, S_ONE, 5'b00011);
    for (int m = 0; m < 4; m++) begin
      wr("R7 set flush and mode", (32'h1 << 24) | 32'(m));
      op("R7 flush single positive", 0, 1, S_ONE, S_ONE, S_SUBP, 5'b0);
      op("R7 flush single negative", 0, 1, S_ONE, S_ONE, S_SUBN, 5'b0);
      op("R7 flush double positive", 1, 1, D_ONE, D_ONE, D_SUBP, 5'b0);
      op("R7 flush double negative", 1, 1, D_ONE, D_ONE, D_SUBN, 5'b0);
    end
    op("R8 raw underflow recorded when flushing", 0, 1, S_ONE, S_ONE, S_ONE, 5'b00011);
    wr("R6 flush with inexact enabled", (32'h1 << 24) | (32'h1 << 7));
    op("R6 subnormal escalates with inexact enable", 1, 1, D_ONE, D_ONE, D_SUBP, 5'b0);
    wr("R10 written unimplemented cause traps", 32'h1 << 17);
    wr("R10 written cause with enable traps", (32'h1 << 15) | (32'h1 << 10));
    wr("R10 written cause without enable", 32'h1 << 16);
    step("R10 write drops coincident op", 1, 0, 1, S_ONE, S_ONE, S_ONE, 5'b00001, 1, 32'h2);
    idle("R11 idle after write");
    op("R12 op after drop", 0, 1, S_ONE, S_ONE, S_ONE, 5'b0);
    idle("R11 final idle");
    repeat (3) @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule